// File: doc/BRIEF.md
# Thermometer to Gray Code Level Encoder

This block takes the one-bit decisions of a bank of parallel threshold comparators, presented as a thermometer word, and turns them into the index of the input level. The width of the index is N bits, and the thermometer word is 2^N-1 bits wide. The index comes out in two forms side by side: plain binary, which is the position of the highest set input bit, and reflected Gray code. Gray bit i is built directly as an XOR of chosen thermometer taps. It is not derived from the binary result.

For a clean input, the binary and Gray outputs name the same level. If a stray high bit appears above the true level, the binary output jumps to the position of the stray bit. The Gray output moves away from the correct code by exactly one bit. This keeps the worst-case error of a corrupted sample small when the Gray path is used downstream.

An optional output stage registers both results and a valid strobe on the rising clock edge. The stage uses a synchronous active-low reset.

Top module: `therm_gray_enc`

## Requirements
- R1: While `rst_n` is low at a rising clock edge, `out_vld`, `bin_out` and `gray_out` become zero after that edge, whatever the inputs are.
- R2: With the output register enabled, `out_vld` equals `in_vld` as it was at the previous rising edge, and `bin_out`/`gray_out` reflect `therm_in` as it was at the previous rising edge.
- R3: `therm_in` bit k-1 carries the decision of threshold k, with k counted from 1 at the lowest threshold. A clean input with its lowest L bits set and all other bits clear gives `bin_out` = L, for every L from 0 to 2^N-1.
- R4: An all-zero `therm_in` gives `bin_out` = 0 and `gray_out` = 0.
- R5: For any input pattern, `bin_out` equals the 1-based position of the highest set bit of `therm_in`. For example, the lowest four bits set plus bit 6 set gives 7.
- R6: For a clean input of level L, `gray_out` = L xor (L >> 1).
- R7: For clean inputs of adjacent levels L and L+1, the two `gray_out` values differ in exactly one bit.
- R8: The most significant bit of `gray_out` equals `therm_in` bit 2^(N-1)-1, which is the mid threshold.
- R9: Take a clean level L and add one stray set bit at 1-based position p, where p > L+1. The resulting `gray_out` differs from the clean Gray code of L in exactly one bit. That bit is at index t, where t is the number of trailing zeros of p.
- R10: Let bit k-1 of `therm_in` be held high, as a comparator stuck at threshold k would hold it. Then `bin_out` equals the larger of k and the true level, for every true level.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock for the output register |
| rst_n | input | 1 | Synchronous active-low reset |
| in_vld | input | 1 | Marks `therm_in` as a valid sample |
| therm_in | input | 2^N-1 | Comparator decisions, bit 0 is the lowest threshold |
| out_vld | output | 1 | Valid strobe aligned with the outputs |
| bin_out | output | N | Highest-set-bit level in binary |
| gray_out | output | N | Level in reflected Gray code, formed from taps |

## Verification
A stray comparator bit and a genuine level arrive in the same sample. The binary path then reports the position of the stray bit, while the Gray path lands one bit away from the true level. The bench provokes this by placing every possible single stray bit above every clean level. For each case it judges the binary result by the highest-set rule, and it judges the Gray result by XOR against the arithmetically computed clean code, which must give a one-hot word at the trailing-zero index. Reset and a valid sample also meet in one cycle. The bench drives a full-scale input with `in_vld` high while reset is held, and requires all outputs to read zero.

// File: rtl/tge_pkg.sv
// Package: shared constants and tap-mask arithmetic for the level encoder.
// Assumes no instance uses more than MAX_LVL_BITS result bits.
package tge_pkg;

    localparam int MAX_LVL_BITS = 8;
    localparam int MAX_TAPS     = (1 << MAX_LVL_BITS) - 1;

    // Count trailing zeros of a nonzero threshold number.
    function automatic int trail_zeros(input int k);
        int n;
        n = 0;
        for (int b = 0; b < MAX_LVL_BITS; b++) begin
            if (((k >> b) & 1) == 0 && n == b) n = b + 1;
        end
        return n;
    endfunction

    // Mask of thresholds whose crossing toggles Gray bit gbit.
    function automatic logic [MAX_TAPS-1:0] tap_mask(input int gbit);
        logic [MAX_TAPS-1:0] m;
        m = '0;
        for (int k = 1; k <= MAX_TAPS; k++) begin
            if (trail_zeros(k) == gbit) m[k-1] = 1'b1;
        end
        return m;
    endfunction

endpackage

// File: rtl/tge_bin_enc.sv
// Module: highest-set-bit encoder. It returns the 1-based position of the
// topmost set input bit, or zero when no bit is set.
// Assumes TAPS = 2^LVL_BITS - 1.
module tge_bin_enc #(
    parameter int LVL_BITS = 4,
    localparam int TAPS    = (1 << LVL_BITS) - 1
) (
    input  logic [TAPS-1:0]     therm,
    output logic [LVL_BITS-1:0] level
);

    // Scan upward; the last set bit seen wins.
    always_comb begin
        level = '0;
        for (int k = 0; k < TAPS; k++) begin
            if (therm[k]) level = LVL_BITS'(k + 1);
        end
    end

endmodule

// File: rtl/tge_gray_taps.sv
// Module: forms each Gray bit as the XOR parity of the thermometer taps at
// which that bit toggles. For a clean input the result is the reflected
// Gray code of the level. A stray bit flips only the one Gray bit that
// belongs to its threshold.
// Assumes LVL_BITS <= tge_pkg::MAX_LVL_BITS.
module tge_gray_taps #(
    parameter int LVL_BITS = 4,
    localparam int TAPS    = (1 << LVL_BITS) - 1
) (
    input  logic [TAPS-1:0]     therm,
    output logic [LVL_BITS-1:0] gray
);

    for (genvar g = 0; g < LVL_BITS; g++) begin : g_bit
        localparam logic [tge_pkg::MAX_TAPS-1:0] FULL = tge_pkg::tap_mask(g);
        localparam logic [TAPS-1:0] MASK = FULL[TAPS-1:0];
        // Parity of the taps selected for this Gray bit.
        assign gray[g] = ^(therm & MASK);
    end

endmodule

// File: rtl/tge_out_stage.sv
// Module: optional output register for both codes and the valid strobe.
// When REG_OUT is 0 the stage is a plain pass-through.
// Assumes the reset is synchronous and active low.
module tge_out_stage #(
    parameter int LVL_BITS = 4,
    parameter bit REG_OUT  = 1'b1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                vld_d,
    input  logic [LVL_BITS-1:0] bin_d,
    input  logic [LVL_BITS-1:0] gray_d,
    output logic                vld_q,
    output logic [LVL_BITS-1:0] bin_q,
    output logic [LVL_BITS-1:0] gray_q
);

    if (REG_OUT) begin : g_reg
        // Capture both codes and the strobe; clear on reset.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                vld_q  <= 1'b0;
                bin_q  <= '0;
                gray_q <= '0;
            end else begin
                vld_q  <= vld_d;
                bin_q  <= bin_d;
                gray_q <= gray_d;
            end
        end
    end else begin : g_comb
        assign vld_q  = vld_d;
        assign bin_q  = bin_d;
        assign gray_q = gray_d;
    end

endmodule

// File: rtl/therm_gray_enc.sv
// Module: top of the level encoder. It turns a 2^N-1 bit comparator
// thermometer word into an N-bit level, given in both binary and Gray.
// Assumes bit 0 of therm_in is the lowest threshold and 3 <= LVL_BITS <= 8.
module therm_gray_enc #(
    parameter int LVL_BITS = 4,
    parameter bit REG_OUT  = 1'b1,
    localparam int TAPS    = (1 << LVL_BITS) - 1
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                in_vld,
    input  logic [TAPS-1:0]     therm_in,
    output logic                out_vld,
    output logic [LVL_BITS-1:0] bin_out,
    output logic [LVL_BITS-1:0] gray_out
);

    logic [LVL_BITS-1:0] bin_c;
    logic [LVL_BITS-1:0] gray_c;

    tge_bin_enc #(.LVL_BITS(LVL_BITS)) bin_i (
        .therm (therm_in),
        .level (bin_c)
    );

    tge_gray_taps #(.LVL_BITS(LVL_BITS)) gray_i (
        .therm (therm_in),
        .gray  (gray_c)
    );

    tge_out_stage #(.LVL_BITS(LVL_BITS), .REG_OUT(REG_OUT)) out_i (
        .clk    (clk),
        .rst_n  (rst_n),
        .vld_d  (in_vld),
        .bin_d  (bin_c),
        .gray_d (gray_c),
        .vld_q  (out_vld),
        .bin_q  (bin_out),
        .gray_q (gray_out)
    );

endmodule

// File: rtl/tge_chk.sv
// Module: assertion checker for therm_gray_enc. The properties are written
// for the registered variant; with REG_OUT = 0 no property is built.
module tge_chk #(
    parameter int LVL_BITS = 4,
    parameter bit REG_OUT  = 1'b1,
    localparam int TAPS    = (1 << LVL_BITS) - 1,
    localparam int MID     = 1 << (LVL_BITS - 1)
) (
    input logic                clk,
    input logic                rst_n,
    input logic                in_vld,
    input logic [TAPS-1:0]     therm_in,
    input logic                out_vld,
    input logic [LVL_BITS-1:0] bin_out,
    input logic [LVL_BITS-1:0] gray_out
);

    if (REG_OUT) begin : g_props
        logic clean_in;
        assign clean_in = ((therm_in & (therm_in + TAPS'(1))) == '0);

        // R1
        reset_clear_chk: assert property (@(posedge clk)
            !rst_n |=> (!out_vld && bin_out == '0 && gray_out == '0));

        // R2
        vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            in_vld |=> out_vld);

        // R2
        no_vld_delay_chk: assert property (@(posedge clk) disable iff (!rst_n)
            !in_vld |=> !out_vld);

        // R4
        zero_in_chk: assert property (@(posedge clk) disable iff (!rst_n)
            (therm_in == '0) |=> (bin_out == '0 && gray_out == '0));

        // R6
        clean_gray_chk: assert property (@(posedge clk) disable iff (!rst_n)
            clean_in |=> (gray_out == (bin_out ^ (bin_out >> 1))));

        // R8
        mid_tap_chk: assert property (@(posedge clk) disable iff (!rst_n)
            1'b1 |=> (gray_out[LVL_BITS-1] == $past(therm_in[MID-1])));

        for (genvar k = 0; k < TAPS; k++) begin : g_floor
            // R10
            stuck_floor_chk: assert property (@(posedge clk) disable iff (!rst_n)
                therm_in[k] |=> (bin_out >= LVL_BITS'(k + 1)));
        end
    end

endmodule

bind therm_gray_enc tge_chk #(.LVL_BITS(LVL_BITS), .REG_OUT(REG_OUT)) chk_i (.*);

// File: tb/therm_gray_enc_tb_top.sv
module therm_gray_enc_tb_top;

    localparam int N    = 4;
    localparam int TAPS = (1 << N) - 1;

    logic            clk = 1'b0;
    logic            rst_n = 1'b0;
    logic            in_vld = 1'b0;
    logic [TAPS-1:0] therm_in = '0;
    logic            out_vld;
    logic [N-1:0]    bin_out;
    logic [N-1:0]    gray_out;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;

    always #10 clk = ~clk;

    therm_gray_enc #(.LVL_BITS(N), .REG_OUT(1'b1)) dut_i (
        .clk(clk), .rst_n(rst_n), .in_vld(in_vld), .therm_in(therm_in),
        .out_vld(out_vld), .bin_out(bin_out), .gray_out(gray_out)
    );

    function automatic logic [TAPS-1:0] clean(input int lvl);
        return TAPS'((1 << lvl) - 1);
    endfunction

    function automatic int tz(input int v);
        int n;
        n = 0;
        while (((v >> n) & 1) == 0) n++;
        return n;
    endfunction

    task automatic check(input string req, input int act, input int exp);
        checks++;
        if (act != exp) begin
            errors++;
            $display("FAIL %s actual %0d expected %0d", req, act, exp);
        end
    endtask

    // Drive at a falling edge; the registered result is sampled one period later.
    task automatic apply(input logic [TAPS-1:0] t, input logic v);
        therm_in = t;
        in_vld   = v;
        @(negedge clk);
    endtask

    initial begin
        int prev_gray;
        @(negedge clk);
        // R1: reset while a full-scale valid sample is presented
        apply('1, 1'b1);
        apply('1, 1'b1);
        check("R1 vld", int'(out_vld), 0);
        check("R1 bin", int'(bin_out), 0);
        check("R1 gray", int'(gray_out), 0);
        rst_n = 1'b1;

        // R3 R4 R6 R7 R8 R2: sweep every clean level
        prev_gray = 0;
        for (int l = 0; l <= TAPS; l++) begin
            logic [TAPS-1:0] t;
            t = clean(l);
            apply(t, 1'b1);
            check("R2 vld", int'(out_vld), 1);
            check("R3 bin", int'(bin_out), l);
            check("R6 gray", int'(gray_out), l ^ (l >> 1));
            check("R8 msb", int'(gray_out[N-1]), int'(t[(1 << (N-1)) - 1]));
            if (l == 0) check("R4 zero gray", int'(gray_out), 0);
            else check("R7 adjacent", $countones(int'(gray_out) ^ prev_gray), 1);
            prev_gray = int'(gray_out);
        end

        // R2: strobe low follows
        apply(clean(3), 1'b0);
        check("R2 novld", int'(out_vld), 0);

        // R5 R9: every single stray bit above every clean level
        for (int l = 0; l <= TAPS - 2; l++) begin
            for (int p = l + 2; p <= TAPS; p++) begin
                logic [TAPS-1:0] t;
                t = clean(l);
                t[p-1] = 1'b1;
                apply(t, 1'b1);
                check("R5 bubble bin", int'(bin_out), p);
                check("R9 bubble gray", int'(gray_out) ^ (l ^ (l >> 1)), 1 << tz(p));
            end
        end

        // R10: threshold 8 stuck high
        for (int l = 0; l <= TAPS; l++) begin
            logic [TAPS-1:0] t;
            t = clean(l);
            t[7] = 1'b1;
            apply(t, 1'b1);
            check("R10 stuck", int'(bin_out), (l > 8) ? l : 8);
        end

        done = 1'b1;
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin
        repeat (5000) @(posedge clk);
        if (!done) begin
            errors++;
            checks++;
            $display("FAIL watchdog actual hung expected done");
            $display("CHECKS %0d ERRORS %0d", checks, errors);
            $finish;
        end
    end

endmodule